// File: doc/BRIEF.md
# Clock Output Gating and Test-Mode Controller

This block is the digital control stage of a motherboard clock generator. Eight groups of source clock phases arrive as ordinary logic inputs: processor, memory, bus, free-running bus, reference, interrupt-controller, serial-bus and I/O. A single fast system clock oversamples them. Three active-low power-management inputs decide which groups run and which are held low. A per-group gate opens or closes only while that group's sampled source is low, so no output ever carries a shortened high pulse.

A two-bit mode input selects one of three kinds of operation. In normal operation the gated clocks drive the outputs. In three-state operation every output enable is dropped. In test operation each group carries a fixed division of an external test clock. The dividers restart together on entry to test mode, so the divided outputs rise on the same test-clock edge. The oscillator and PLL are represented only by two enable outputs. These fall once power-down has closed every gate, and they rise again when power-down is released.

Top module: `clkgen_ctl`

## Requirements
- R1: While `rst_n` is low, all `clk_out` bits are 0, all `clk_oe` bits are 1, and `osc_en` and `pll_en` are 0.
- R2: With `pwr_dwn_n` low, every `clk_out` bit settles low and stays low whatever the two stop inputs are. `osc_en` and `pll_en` fall only after every group gate has closed.
- R3: With `pwr_dwn_n` high and `cpu_stop_n` low, bit 0 (processor group) settles low. Bits 1 to 7 keep toggling.
- R4: With `pwr_dwn_n` high and `pci_stop_n` low, bit 2 (bus group) settles low. Bit 3 (free-running bus) and all other bits keep toggling.
- R5: With `pwr_dwn_n` high and both stops low, bits 0 and 2 are low. Bits 1 and 3 to 7 keep toggling.
- R6: A group gate changes state only while that group's sampled source is low. Every high pulse on an output in normal operation lasts a full high phase of its source. Control inputs pass through a `SYNC_STAGES` synchronizer first.
- R7: `mode` = 01 (three-state) drives all `clk_oe` bits to 0 and all `clk_out` bits to 0.
- R8: `mode` = 10 (test) sets all `clk_oe` bits to 1. Bits 0, 1 and 6 carry `tclk`/2. Bits 2, 3 and 7 carry `tclk`/4. Bits 4 and 5 carry `tclk` undivided.
- R9: On entry to test mode all divided outputs are low. The first rising `tclk` edge that follows raises bits 0, 2 and 4 in the same cycle.
- R10: `mode` = 11 behaves exactly as normal operation (00), with all `clk_oe` bits at 1.
- R11: Once `pwr_dwn_n` is high again and has passed the synchronizer, `osc_en` and `pll_en` return to 1. All groups then run, subject to the stop inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | 8 | Source clock phases, one per group (bit 0 processor ... bit 7 I/O) |
| tclk | input | 1 | External test clock |
| cpu_stop_n | input | 1 | Active-low stop for the processor group |
| pci_stop_n | input | 1 | Active-low stop for the bus group |
| pwr_dwn_n | input | 1 | Active-low power-down |
| mode | input | 2 | 00 normal, 01 three-state, 10 test, 11 treated as normal |
| clk_out | output | 8 | Output clock value per group |
| clk_oe | output | 8 | Output enable per group (0 models high impedance) |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
Suppose a group gate is stuck or is updated while its source is high. The port shows a missing clock or a short high pulse within one source period of the control change, and the pulse-width monitor and the per-cycle model compare both catch it. A divider counter that is not cleared on entry to test mode shows up at the first test-clock rise: the divided outputs either fail to rise together or rise before it. A wrong rise count over an aligned window exposes a wrong ratio. A wrong enable register shows up one cycle after the last gate closes or after power-down is released.

// File: rtl/clkgen_ctl_pkg.sv
// Shared constants, group map and per-group attributes for the clock
// output controller. Assumes eight fixed output groups.
package clkgen_ctl_pkg;

    localparam int NUM_GRP = 8;

    localparam int GRP_CPU   = 0;
    localparam int GRP_SDRAM = 1;
    localparam int GRP_PCI   = 2;
    localparam int GRP_PCIF  = 3;
    localparam int GRP_REF   = 4;
    localparam int GRP_APIC  = 5;
    localparam int GRP_USB   = 6;
    localparam int GRP_IO    = 7;

    // Control vector bit positions after synchronization.
    localparam int CTL_PWR = 0;
    localparam int CTL_CPU = 1;
    localparam int CTL_PCI = 2;
    localparam int CTL_W   = 3;

    // Largest test divide ratio expressed as log2.
    localparam int DIV_LOG2_MAX = 2;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_HIZ  = 2'b01,
        MODE_TEST = 2'b10,
        MODE_ALT  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        STOP_NONE = 2'd0,
        STOP_CPU  = 2'd1,
        STOP_PCI  = 2'd2
    } stop_class_e;

    // Which stop input, besides power-down, gates a group.
    function automatic stop_class_e grp_stop_class(input int g);
        case (g)
            GRP_CPU: return STOP_CPU;
            GRP_PCI: return STOP_PCI;
            default: return STOP_NONE;
        endcase
    endfunction

    // log2 of the test-mode divide ratio for a group.
    function automatic int grp_div_log2(input int g);
        case (g)
            GRP_CPU, GRP_SDRAM, GRP_USB: return 1;
            GRP_PCI, GRP_PCIF, GRP_IO:   return 2;
            default:                     return 0;
        endcase
    endfunction

endpackage

// File: rtl/clkgen_ctl_sync.sv
// Multi-stage synchronizer for asynchronous control levels.
// Assumes inputs are slow levels; every bit resets to RST_VAL.
module clkgen_ctl_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/clkgen_ctl_gate.sv
// One output group's sampler and gate. The source phase is registered,
// and the gate follows the run request only while the registered
// source is low, so the gated result never starts or ends mid-pulse.
// Assumes the source is slower than half the system clock rate.
module clkgen_ctl_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic run_req,
    output logic src_q,
    output logic gate_q
);

    // Sample the source and move the gate only in its low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            src_q <= src;
            if (!src_q) gate_q <= run_req;
        end
    end

endmodule

// File: rtl/clkgen_ctl_testdiv.sv
// Test-clock divider bank. Samples tclk, counts its rising edges while
// active, and holds the counter in a preset state when inactive so all
// taps rise together on the first edge after activation.
// Tap k carries tclk divided by 2**k.
module clkgen_ctl_testdiv #(
    parameter int LOG2 = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tclk,
    input  logic          active,
    output logic [LOG2:0] tap
);

    logic            tclk_q;
    logic            started;
    logic [LOG2-1:0] cnt;
    logic            tclk_rise;

    assign tclk_rise = tclk & ~tclk_q;

    // Track tclk, preset when idle, count rising edges when active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tclk_q  <= 1'b0;
            started <= 1'b0;
            cnt     <= '1;
        end else begin
            tclk_q <= tclk;
            if (!active) begin
                cnt     <= '1;
                started <= 1'b0;
            end else if (tclk_rise) begin
                cnt     <= cnt + 1'b1;
                started <= 1'b1;
            end
        end
    end

    assign tap[0] = tclk_q & started;

    for (genvar k = 1; k <= LOG2; k++) begin : g_tap
        assign tap[k] = ~cnt[k-1];
    end

endmodule

// File: rtl/clkgen_ctl.sv
// Clock output gating and test-mode controller (top).
// Oversamples eight source clock phases on clk, gates each group from
// the synchronized power-management inputs without runt pulses, and
// selects normal, high-impedance or divided test-clock output per group.
// Assumes sources and tclk run below half the clk rate.
module clkgen_ctl
    import clkgen_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] src_clk,
    input  logic               tclk,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               pwr_dwn_n,
    input  logic [1:0]         mode,
    output logic [NUM_GRP-1:0] clk_out,
    output logic [NUM_GRP-1:0] clk_oe,
    output logic               osc_en,
    output logic               pll_en
);

    logic [CTL_W-1:0]        ctl_raw;
    logic [CTL_W-1:0]        ctl_s;
    mode_e                   mode_q;
    logic [NUM_GRP-1:0]      run_req;
    logic [NUM_GRP-1:0]      gate_open;
    logic [NUM_GRP-1:0]      src_seen;
    logic [NUM_GRP-1:0]      gated;
    logic [NUM_GRP-1:0]      test_out;
    logic [DIV_LOG2_MAX:0]   div_tap;
    logic                    en_q;

    assign ctl_raw[CTL_PWR] = pwr_dwn_n;
    assign ctl_raw[CTL_CPU] = cpu_stop_n;
    assign ctl_raw[CTL_PCI] = pci_stop_n;

    clkgen_ctl_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    // Register the mode strap once; it is a quasi-static select.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_e'(mode);
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        if (grp_stop_class(g) == STOP_CPU) begin : g_cpu
            assign run_req[g] = ctl_s[CTL_PWR] & ctl_s[CTL_CPU];
        end else if (grp_stop_class(g) == STOP_PCI) begin : g_pci
            assign run_req[g] = ctl_s[CTL_PWR] & ctl_s[CTL_PCI];
        end else begin : g_free
            assign run_req[g] = ctl_s[CTL_PWR];
        end

        clkgen_ctl_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_clk[g]),
            .run_req (run_req[g]),
            .src_q   (src_seen[g]),
            .gate_q  (gate_open[g])
        );

        assign gated[g]    = src_seen[g] & gate_open[g];
        assign test_out[g] = div_tap[grp_div_log2(g)];
    end

    clkgen_ctl_testdiv #(
        .LOG2 (DIV_LOG2_MAX)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tclk   (tclk),
        .active (mode_q == MODE_TEST),
        .tap    (div_tap)
    );

    // Keep oscillator and PLL on until every gate has closed.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= ctl_s[CTL_PWR] | (|gate_open);
    end

    assign osc_en = en_q;
    assign pll_en = en_q;

    // Select the output source and enable from the registered mode.
    always_comb begin
        case (mode_q)
            MODE_HIZ: begin
                clk_out = '0;
                clk_oe  = '0;
            end
            MODE_TEST: begin
                clk_out = test_out;
                clk_oe  = '1;
            end
            default: begin
                clk_out = gated;
                clk_oe  = '1;
            end
        endcase
    end

endmodule

// File: rtl/clkgen_ctl_chk.sv
// Assertion checker for clkgen_ctl, attached by bind. Observes ports and
// the per-group gate and sampled-source state.
module clkgen_ctl_chk
    import clkgen_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic [NUM_GRP-1:0] clk_out,
    input logic [NUM_GRP-1:0] clk_oe,
    input logic               pll_en,
    input logic [NUM_GRP-1:0] gate_open,
    input logic [NUM_GRP-1:0] src_seen
);

    // R6: a gate may only change while its sampled source was low.
    assert_gate_when_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((gate_open ^ $past(gate_open)) & $past(src_seen)) == '0));

    // R2: enables only fall once every gate is closed.
    assert_enables_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(pll_en)) |-> (gate_open == '0));

    // R2: in a clock-driving mode, closed gates give low outputs.
    assert_closed_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) != 2'b01 && $past(mode) != 2'b10 && gate_open == '0)
        |-> (clk_out == '0));

    // R7: three-state mode removes every output enable.
    assert_tristate_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b01) |-> (clk_oe == '0));

    // R8: test mode enables every output.
    assert_test_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b10) |-> (clk_oe == '1));

    // R10: reserved mode enables every output like normal mode.
    assert_alt_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b11) |-> (clk_oe == '1));

    // R9: divide-by-4 rises only together with divide-by-2 and undivided.
    assert_div_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b10 && $past(mode, 2) == 2'b10
         && $rose(clk_out[GRP_PCI]))
        |-> ($rose(clk_out[GRP_CPU]) && $rose(clk_out[GRP_REF])));

endmodule

bind clkgen_ctl clkgen_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .clk_out   (clk_out),
    .clk_oe    (clk_oe),
    .pll_en    (pll_en),
    .gate_open (gate_open),
    .src_seen  (src_seen)
);

// File: tb/tb_clkgen_ctl.sv
`timescale 1ns/1ps
module tb_clkgen_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src = '0;
    logic       tclk = 1'b0;
    logic       cpu_stop_n = 1'b1;
    logic       pci_stop_n = 1'b1;
    logic       pwr_dwn_n = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [7:0] clk_out;
    logic [7:0] clk_oe;
    logic       osc_en;
    logic       pll_en;

    always #2 clk = ~clk;

    clkgen_ctl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_clk    (src),
        .tclk       (tclk),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .pwr_dwn_n  (pwr_dwn_n),
        .mode       (mode),
        .clk_out    (clk_out),
        .clk_oe     (clk_oe),
        .osc_en     (osc_en),
        .pll_en     (pll_en)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Source clocks: per-group periods in clk cycles, staggered phases.
    int per  [8] = '{6, 6, 12, 12, 14, 14, 4, 8};
    int dlog [8] = '{1, 1, 2, 2, 0, 0, 1, 2};
    int ph   [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
    int tph = 0;

    always @(negedge clk) begin
        for (int g = 0; g < 8; g++) begin
            ph[g]  = (ph[g] + 1) % per[g];
            src[g] = (ph[g] < per[g] / 2);
        end
        tph  = (tph + 1) % 8;
        tclk = (tph < 4);
    end

    // Behavioural reference model, advanced on each rising clk edge.
    logic [2:0] m_s1, m_s2;
    logic [7:0] m_sq, m_gate;
    logic       m_en, m_tq, m_started;
    logic [1:0] m_cnt, m_mode;
    logic       pw, cs, ps;
    bit         m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_sq = '0; m_gate = '0; m_en = 1'b0;
            m_mode = 2'b00; m_tq = 1'b0; m_started = 1'b0; m_cnt = 2'b11;
            m_valid = 1;
        end else begin
            pw = m_s2[0]; cs = m_s2[1]; ps = m_s2[2];
            m_en = pw | (|m_gate);
            for (int g = 0; g < 8; g++)
                if (!m_sq[g]) m_gate[g] = (g == 0) ? (pw & cs) : (g == 2) ? (pw & ps) : pw;
            m_sq = src;
            m_s2 = m_s1;
            m_s1 = {pci_stop_n, cpu_stop_n, pwr_dwn_n};
            if (m_mode != 2'b10) begin
                m_cnt = 2'b11; m_started = 1'b0;
            end else if (tclk && !m_tq) begin
                m_cnt = m_cnt + 2'd1; m_started = 1'b1;
            end
            m_tq   = tclk;
            m_mode = mode;
        end
    end

    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        for (int g = 0; g < 8; g++) begin
            if (m_mode == 2'b01) r[g] = 1'b0;
            else if (m_mode == 2'b10)
                r[g] = (dlog[g] == 0) ? (m_tq & m_started) :
                       (dlog[g] == 1) ? ~m_cnt[0] : ~m_cnt[1];
            else r[g] = m_sq[g] & m_gate[g];
        end
        return r;
    endfunction

    // Per-cycle comparison and R6 pulse-width monitor.
    int   hl [8];
    bit   clean [8];

    always @(negedge clk) begin
        if (m_valid) begin
            chk(clk_out == exp_out(), cur_req, clk_out, exp_out());
            chk(clk_oe == ((m_mode == 2'b01) ? 8'h00 : 8'hff), cur_req, clk_oe,
                (m_mode == 2'b01) ? 0 : 255);
            chk(pll_en == m_en && osc_en == m_en, cur_req, {osc_en, pll_en}, {m_en, m_en});
        end
        for (int g = 0; g < 8; g++) begin
            if (!rst_n || m_mode == 2'b01 || m_mode == 2'b10) begin
                clean[g] = 0; hl[g] = 0;
            end else if (clk_out[g]) begin
                hl[g]++;
            end else begin
                if (hl[g] > 0 && clean[g]) chk(hl[g] >= per[g] / 2, "R6", hl[g], per[g] / 2);
                clean[g] = 1; hl[g] = 0;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int tog [8];
    int rse [8];

    task automatic watch(input int n);
        logic [7:0] p;
        for (int g = 0; g < 8; g++) begin tog[g] = 0; rse[g] = 0; end
        p = clk_out;
        repeat (n) begin
            @(negedge clk);
            for (int g = 0; g < 8; g++) begin
                if (clk_out[g] != p[g]) tog[g]++;
                if (clk_out[g] && !p[g]) rse[g]++;
            end
            p = clk_out;
        end
    endtask

    task automatic run_check(input string req, input logic [7:0] stopped);
        watch(60);
        for (int g = 0; g < 8; g++) begin
            if (stopped[g]) chk(tog[g] == 0 && clk_out[g] == 1'b0, req, tog[g], 0);
            else            chk(tog[g] > 0, req, tog[g], 1);
        end
    endtask

    task automatic entry_check();
        logic [7:0] p;
        bit found;
        found = 0;
        p = clk_out;
        mode = 2'b10;
        for (int k = 0; k < 40 && !found; k++) begin
            @(negedge clk);
            if (clk_out[4] && !p[4]) found = 1;
            else p = clk_out;
        end
        chk(found, "R9", found, 1);
        chk(clk_out[0] && !p[0], "R9", {p[0], clk_out[0]}, 1);
        chk(clk_out[2] && !p[2], "R9", {p[2], clk_out[2]}, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        cur_req = "R1";
        chk(clk_out == 8'h00, "R1", clk_out, 0);
        chk(clk_oe == 8'hff, "R1", clk_oe, 255);
        chk(!osc_en && !pll_en, "R1", {osc_en, pll_en}, 0);
        rst_n = 1'b1;

        cur_req = "R11";
        repeat (30) @(negedge clk);
        chk(osc_en && pll_en, "R11", {osc_en, pll_en}, 3);
        run_check("R6", 8'h00);

        cpu_stop_n = 1'b0; cur_req = "R3";
        repeat (30) @(negedge clk);
        run_check("R3", 8'h01);

        cpu_stop_n = 1'b1; pci_stop_n = 1'b0; cur_req = "R4";
        repeat (30) @(negedge clk);
        run_check("R4", 8'h04);

        cpu_stop_n = 1'b0; cur_req = "R5";
        repeat (30) @(negedge clk);
        run_check("R5", 8'h05);

        pwr_dwn_n = 1'b0; cur_req = "R2";
        repeat (30) @(negedge clk);
        chk(!osc_en && !pll_en, "R2", {osc_en, pll_en}, 0);
        run_check("R2", 8'hff);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (10) @(negedge clk);
        run_check("R2", 8'hff);

        pwr_dwn_n = 1'b1; cur_req = "R11";
        repeat (30) @(negedge clk);
        chk(osc_en && pll_en, "R11", {osc_en, pll_en}, 3);
        run_check("R11", 8'h00);

        cur_req = "R6";
        for (int i = 0; i < 40; i++) begin
            cpu_stop_n = ~cpu_stop_n;
            pci_stop_n = (i % 3 == 0) ? ~pci_stop_n : pci_stop_n;
            repeat (5) @(negedge clk);
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (30) @(negedge clk);

        mode = 2'b11; cur_req = "R10";
        repeat (10) @(negedge clk);
        chk(clk_oe == 8'hff, "R10", clk_oe, 255);
        run_check("R10", 8'h00);

        mode = 2'b01; cur_req = "R7";
        repeat (5) @(negedge clk);
        chk(clk_oe == 8'h00, "R7", clk_oe, 0);
        chk(clk_out == 8'h00, "R7", clk_out, 0);
        watch(30);
        for (int g = 0; g < 8; g++) chk(tog[g] == 0, "R7", tog[g], 0);

        mode = 2'b00; cur_req = "R9";
        repeat (20) @(negedge clk);
        entry_check();

        cur_req = "R8";
        repeat (8) @(negedge clk);
        chk(clk_oe == 8'hff, "R8", clk_oe, 255);
        watch(256);
        for (int g = 0; g < 8; g++) chk(rse[g] == (32 >> dlog[g]), "R8", rse[g], 32 >> dlog[g]);

        mode = 2'b00; cur_req = "R9";
        repeat (23) @(negedge clk);
        entry_check();
        repeat (40) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule